// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block buffers 36-bit words between two independent, free-running clocks. A producer writes on `wr_clk` and a consumer reads on `rd_clk`. The two clocks may be unrelated or the very same clock. The read side works in show-ahead mode. The oldest stored word is moved into an output register, and `rd_valid` rises when it is there. A read strobe consumes that word and fetches the next one. Each side keeps a binary pointer. The pointer crosses into the other domain as Gray code through two flip-flops. Each side computes its own flags from its own pointer and the synchronized copy of the other side's pointer.

Two threshold flags give early warning: `wr_afull` in the write domain and `rd_aempty` in the read domain. Their offsets start at parameter defaults after reset. Software can replace them once, in one of two ways. The first is a parallel load from the write data bus. The second is a serial stream of bits. A small configuration state machine has three states: `OFS_DEFAULT` (defaults in use), `OFS_SHIFT` (serial stream in progress) and `OFS_LOCKED` (programmed). Its transitions are:
- `OFS_DEFAULT -> OFS_LOCKED` on a parallel load.
- `OFS_DEFAULT -> OFS_SHIFT` on the first serial bit.
- `OFS_SHIFT -> OFS_LOCKED` on the last serial bit.
- `OFS_LOCKED` is left only by reset.

Retransmit lets the consumer go back over earlier data. A mark state machine has two states, `MK_FREE` and `MK_HELD`. `MK_FREE -> MK_HELD` happens on `rtx_mark`, which records the position of the word currently presented. `MK_HELD -> MK_FREE` happens on `rtx_clr`. While the mark is held, `rtx_go` rewinds the read pointer to the mark. The marked words are then presented again in the same order.

The read output state machine has two states:
- `RD_EMPTY -> RD_SHOW` when a word is fetched.
- `RD_SHOW -> RD_SHOW` when a read consumes a word and another one is available.
- `RD_SHOW -> RD_EMPTY` when a read consumes the last word.
- Any state `-> RD_EMPTY` on a rewind.

While the mark is held, the words from the mark onward are protected from being overwritten.

Top module: `xfifo_rtx`

## Requirements
- R1: After reset the block reports `wr_ready`=1, `wr_afull`=0, `rd_valid`=0 and `rd_aempty`=1.
- R2: Words leave in the order they were written. While `rd_valid` is high and `rd_en` is low, `rd_data` holds steady.
- R3: With DEPTH words stored (counting the word on the output), `wr_ready` is 0. Writes presented then are dropped and never reach the read port.
- R4: A read strobe while `rd_valid` is 0 has no effect, and data written afterwards is read intact.
- R5: `wr_afull` is 1 exactly when free space (DEPTH minus stored words) is at or below the almost-full offset.
- R6: `rd_aempty` is 1 exactly when the stored word count, including the word on the output, is at or below the almost-empty offset.
- R7: After reset both offsets equal their default parameters (8 and 8).
- R8: `ofs_load` high at a `wr_clk` edge in the default state loads the almost-empty offset from `wr_data` bits [OW-1:0] and the almost-full offset from bits [18+OW-1:18], where OW = log2(DEPTH)+1. That word is not stored.
- R9: `ofs_ser_en` high for 2*OW `wr_clk` edges shifts in `ofs_ser_bit` most significant bit first. The first OW bits form the almost-full offset and the last OW bits form the almost-empty offset. The new offsets take effect after the last bit.
- R10: Once offsets are programmed, both by either path, further parallel or serial loads are ignored until reset.
- R11: `rtx_mark` records the word on the output, or the next word if none is shown. A later `rtx_go` while the mark is held drops the output and presents the marked word and its successors again.
- R12: While the mark is held, free space is counted from the mark, so `wr_ready` falls once DEPTH words lie between the mark and the write pointer. After `rtx_clr` the space is given back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low asynchronous reset for both sides |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Write word; also carries offsets on a parallel load |
| wr_ready | output | 1 | Space available; writes taken only when high |
| wr_afull | output | 1 | Free space at or below almost-full offset |
| ofs_load | input | 1 | Parallel offset load from `wr_data` |
| ofs_ser_en | input | 1 | Serial offset bit strobe |
| ofs_ser_bit | input | 1 | Serial offset data bit |
| rd_en | input | 1 | Read strobe; consumes the shown word |
| rd_data | output | 36 | Shown word |
| rd_valid | output | 1 | A word is on `rd_data` |
| rd_aempty | output | 1 | Stored count at or below almost-empty offset |
| rtx_mark | input | 1 | Record retransmit position |
| rtx_go | input | 1 | Rewind reads to the recorded position |
| rtx_clr | input | 1 | Release the recorded position |

## Verification
The properties assume several things about the stimulus.
- `rst_n` is asserted with both clocks running.
- Offsets are changed only while the queue is idle, because the almost-empty offset crosses into the read domain as a quasi-static word.
- `ofs_load` is not used to carry payload.

The stimulus reprograms offsets only right after a reset or with the queue empty, and it raises `rtx_go` only while a mark is held. All strobes are driven a few nanoseconds after the owning clock edge, so the properties see clean, single-edge events. The scoreboard order check covers both plain streaming and replay after a rewind.

// File: rtl/xf_pkg.sv
package xf_pkg;

    typedef enum logic [1:0] {
        OFS_DEFAULT,
        OFS_SHIFT,
        OFS_LOCKED
    } ofs_state_e;

    typedef enum logic {
        RD_EMPTY,
        RD_SHOW
    } rd_state_e;

    typedef enum logic {
        MK_FREE,
        MK_HELD
    } mk_state_e;

endpackage

// File: rtl/xf_gray_xing.sv
// Carries a binary pointer into another clock domain as Gray code.
module xf_gray_xing #(
    parameter int W = 10
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_bin,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] g_src;
    logic [W-1:0] g_meta;
    logic [W-1:0] g_dst;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) g_src <= '0;
        else        g_src <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            g_meta <= '0;
            g_dst  <= '0;
        end else begin
            g_meta <= g_src;
            g_dst  <= g_meta;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) dst_bin[i] = ^(g_dst >> i);
    end
endmodule

// File: rtl/xf_mem.sv
// Storage array: one synchronous write port, one combinational read port.
module xf_mem #(
    parameter int W  = 36,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int N = 1 << AW;

    logic [W-1:0] ram [N];

    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/xf_ofs_cfg.sv
// Threshold offset register set: defaults, one parallel or one serial load.
module xf_ofs_cfg
    import xf_pkg::*;
#(
    parameter int W      = 36,
    parameter int OW     = 10,
    parameter int HALF   = 18,
    parameter int AF_DEF = 8,
    parameter int AE_DEF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  ld_word,
    input  logic          ser_en,
    input  logic          ser_bit,
    output logic [OW-1:0] af_ofs,
    output logic [OW-1:0] ae_ofs,
    output logic          locked
);
    localparam int SW = 2 * OW;
    localparam int CW = $clog2(SW + 1);

    ofs_state_e    st, st_n;
    logic [SW-1:0] sh, sh_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [OW-1:0] af_n, ae_n;
    logic [SW-1:0] sh_shift;

    assign sh_shift = {sh[SW-2:0], ser_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= OFS_DEFAULT;
            sh     <= '0;
            cnt    <= '0;
            af_ofs <= OW'(AF_DEF);
            ae_ofs <= OW'(AE_DEF);
        end else begin
            st     <= st_n;
            sh     <= sh_n;
            cnt    <= cnt_n;
            af_ofs <= af_n;
            ae_ofs <= ae_n;
        end
    end

    always_comb begin
        st_n  = st;
        sh_n  = sh;
        cnt_n = cnt;
        af_n  = af_ofs;
        ae_n  = ae_ofs;
        unique case (st)
            OFS_DEFAULT: begin
                if (load) begin
                    af_n = ld_word[HALF +: OW];
                    ae_n = ld_word[0 +: OW];
                    st_n = OFS_LOCKED;
                end else if (ser_en) begin
                    sh_n  = sh_shift;
                    cnt_n = CW'(1);
                    st_n  = OFS_SHIFT;
                end
            end
            OFS_SHIFT: begin
                if (ser_en) begin
                    sh_n  = sh_shift;
                    cnt_n = cnt + 1'b1;
                    if (cnt == CW'(SW - 1)) begin
                        {af_n, ae_n} = sh_shift;
                        st_n         = OFS_LOCKED;
                    end
                end
            end
            OFS_LOCKED: begin
                st_n = OFS_LOCKED;
            end
        endcase
    end

    assign locked = (st == OFS_LOCKED);
endmodule

// File: rtl/xf_rd_ctrl.sv
// Read side: show-ahead output register, retransmit mark and guard pointer.
module xf_rd_ctrl
    import xf_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rtx_mark,
    input  logic          rtx_go,
    input  logic          rtx_clr,
    input  logic [AW:0]   wbin_s,
    input  logic [W-1:0]  mem_q,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  dout,
    output logic          valid,
    output logic [AW:0]   cur,
    output logic [AW:0]   tail,
    output logic          held
);
    localparam int PW = AW + 1;

    rd_state_e     st, st_n;
    mk_state_e     mk, mk_n;
    logic [PW-1:0] rptr, rptr_n, mark, mark_n, tail_n, tgt;
    logic [W-1:0]  dq, dq_n;
    logic          avail, fetch, rewind;

    assign cur      = (st == RD_SHOW) ? rptr - 1'b1 : rptr;
    assign avail    = (wbin_s != rptr);
    assign rewind   = rtx_go && (mk == MK_HELD);
    assign mem_addr = rptr[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RD_EMPTY;
            mk   <= MK_FREE;
            rptr <= '0;
            mark <= '0;
            tail <= '0;
            dq   <= '0;
        end else begin
            st   <= st_n;
            mk   <= mk_n;
            rptr <= rptr_n;
            mark <= mark_n;
            tail <= tail_n;
            dq   <= dq_n;
        end
    end

    // output register state machine
    always_comb begin
        st_n   = st;
        rptr_n = rptr;
        dq_n   = dq;
        fetch  = 1'b0;
        unique case (st)
            RD_EMPTY: fetch = !rewind && avail;
            RD_SHOW:  fetch = !rewind && rd_en && avail;
        endcase
        if (rewind) begin
            rptr_n = mark;
            st_n   = RD_EMPTY;
        end else if (fetch) begin
            rptr_n = rptr + 1'b1;
            dq_n   = mem_q;
            st_n   = RD_SHOW;
        end else if (st == RD_SHOW && rd_en) begin
            st_n = RD_EMPTY;
        end
    end

    // retransmit mark state machine and guard pointer (steps by at most one)
    always_comb begin
        mk_n   = mk;
        mark_n = mark;
        unique case (mk)
            MK_FREE: begin
                if (rtx_mark) begin
                    mark_n = cur;
                    mk_n   = MK_HELD;
                end
            end
            MK_HELD: begin
                if (rtx_mark && !rtx_go)     mark_n = cur;
                else if (rtx_clr && !rtx_go) mk_n   = MK_FREE;
            end
        endcase
        tgt    = (mk == MK_HELD) ? mark : cur;
        tail_n = (tail != tgt) ? tail + 1'b1 : tail;
    end

    assign dout  = dq;
    assign valid = (st == RD_SHOW);
    assign held  = (mk == MK_HELD);
endmodule

// File: rtl/xfifo_rtx.sv
module xfifo_rtx #(
    parameter int WIDTH      = 36,
    parameter int DEPTH      = 512,
    parameter int AF_DEFAULT = 8,
    parameter int AE_DEFAULT = 8
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             wr_afull,
    input  logic             ofs_load,
    input  logic             ofs_ser_en,
    input  logic             ofs_ser_bit,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_aempty,
    input  logic             rtx_mark,
    input  logic             rtx_go,
    input  logic             rtx_clr
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PW   = AW + 1;
    localparam int OW   = PW;
    localparam int HALF = WIDTH / 2;

    logic [PW-1:0]    wptr_bin, wptr_s, tail_bin, tail_s, cur_ptr;
    logic [PW-1:0]    used_w, free_w, level_r;
    logic [OW-1:0]    af_ofs, ae_ofs, ae_m, ae_r;
    logic [AW-1:0]    rd_addr;
    logic [WIDTH-1:0] mem_q;
    logic             cfg_locked, rtx_held, do_wr;

    xf_ofs_cfg #(
        .W(WIDTH), .OW(OW), .HALF(HALF), .AF_DEF(AF_DEFAULT), .AE_DEF(AE_DEFAULT)
    ) u_cfg (
        .clk(wr_clk), .rst_n(rst_n), .load(ofs_load), .ld_word(wr_data),
        .ser_en(ofs_ser_en), .ser_bit(ofs_ser_bit),
        .af_ofs(af_ofs), .ae_ofs(ae_ofs), .locked(cfg_locked)
    );

    // write domain
    assign used_w   = wptr_bin - tail_s;
    assign free_w   = PW'(DEPTH) - used_w;
    assign wr_ready = (used_w != PW'(DEPTH));
    assign wr_afull = (free_w <= af_ofs);
    assign do_wr    = wr_en && wr_ready && !ofs_load;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wptr_bin <= '0;
        else        wptr_bin <= wptr_bin + PW'(do_wr);
    end

    xf_mem #(.W(WIDTH), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(do_wr), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
        .raddr(rd_addr), .rdata(mem_q)
    );

    xf_gray_xing #(.W(PW)) u_w2r (
        .src_clk(wr_clk), .dst_clk(rd_clk), .rst_n(rst_n),
        .src_bin(wptr_bin), .dst_bin(wptr_s)
    );

    xf_gray_xing #(.W(PW)) u_r2w (
        .src_clk(rd_clk), .dst_clk(wr_clk), .rst_n(rst_n),
        .src_bin(tail_bin), .dst_bin(tail_s)
    );

    // read domain
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_m <= OW'(AE_DEFAULT);
            ae_r <= OW'(AE_DEFAULT);
        end else begin
            ae_m <= ae_ofs;
            ae_r <= ae_m;
        end
    end

    xf_rd_ctrl #(.W(WIDTH), .AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en),
        .rtx_mark(rtx_mark), .rtx_go(rtx_go), .rtx_clr(rtx_clr),
        .wbin_s(wptr_s), .mem_q(mem_q), .mem_addr(rd_addr),
        .dout(rd_data), .valid(rd_valid), .cur(cur_ptr), .tail(tail_bin), .held(rtx_held)
    );

    assign level_r   = wptr_s - cur_ptr;
    assign rd_aempty = (level_r <= ae_r);
endmodule

// File: rtl/xfifo_rtx_chk.sv
module xfifo_rtx_chk #(
    parameter int PW    = 10,
    parameter int OW    = 10,
    parameter int WIDTH = 36
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             wr_ready,
    input logic             wr_afull,
    input logic [PW-1:0]    wptr_bin,
    input logic [PW-1:0]    tail_bin,
    input logic             rd_valid,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             rtx_go,
    input logic             rtx_held,
    input logic             cfg_locked,
    input logic [OW-1:0]    af_ofs,
    input logic [OW-1:0]    ae_ofs
);
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_ready |=> $stable(wptr_bin)); // R3

    AST_AFULL_AT_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_ready |-> wr_afull); // R5

    AST_OUTPUT_HELD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_valid && !rd_en && !rtx_go) |=> (rd_valid && $stable(rd_data))); // R2

    AST_REWIND_DROPS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rtx_go && rtx_held) |=> !rd_valid); // R11

    AST_GUARD_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ((tail_bin - $past(tail_bin)) <= PW'(1))); // R12

    AST_OFS_FROZEN: assert property (@(posedge wr_clk) disable iff (!rst_n)
        cfg_locked |=> (cfg_locked && $stable(af_ofs) && $stable(ae_ofs))); // R10
endmodule

bind xfifo_rtx xfifo_rtx_chk #(.PW(PW), .OW(OW), .WIDTH(WIDTH)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_ready(wr_ready), .wr_afull(wr_afull), .wptr_bin(wptr_bin), .tail_bin(tail_bin),
    .rd_valid(rd_valid), .rd_en(rd_en), .rd_data(rd_data),
    .rtx_go(rtx_go), .rtx_held(rtx_held),
    .cfg_locked(cfg_locked), .af_ofs(af_ofs), .ae_ofs(ae_ofs)
);

// File: tb/xfifo_rtx_tb.sv
module xfifo_rtx_tb;
    localparam int WIDTH = 36;
    localparam int DEPTH = 512;
    localparam int OW    = $clog2(DEPTH) + 1;
    localparam int HALF  = WIDTH / 2;

    logic             wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic             wr_en = 1'b0, ofs_load = 1'b0, ofs_ser_en = 1'b0, ofs_ser_bit = 1'b0;
    logic             rd_en = 1'b0, rtx_mark = 1'b0, rtx_go = 1'b0, rtx_clr = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             wr_ready, wr_afull, rd_valid, rd_aempty;

    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    xfifo_rtx u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .wr_afull(wr_afull),
        .ofs_load(ofs_load), .ofs_ser_en(ofs_ser_en), .ofs_ser_bit(ofs_ser_bit),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_aempty(rd_aempty),
        .rtx_mark(rtx_mark), .rtx_go(rtx_go), .rtx_clr(rtx_clr)
    );

    logic [WIDTH-1:0] q[$];
    int    checks = 0;
    int    fails  = 0;
    string req    = "R2";

    task automatic check(input string r, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // scoreboard monitor: a read happens at the next rd_clk edge
    always @(negedge rd_clk) begin
        if (rst_n && rd_en && rd_valid) begin
            if (q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL %s unexpected word: actual %0h expected none", req, rd_data);
            end else begin
                check(req, rd_data, q.pop_front(), "read word");
            end
        end
    end

    task automatic settle();
        repeat (8) @(posedge rd_clk);
        @(negedge wr_clk);
    endtask

    task automatic put(input logic [WIDTH-1:0] w);
        @(posedge wr_clk);
        #2;
        wr_en   = 1'b1;
        wr_data = w;
        if (wr_ready) q.push_back(w);
        @(posedge wr_clk);
        #2;
        wr_en = 1'b0;
    endtask

    task automatic fill(input int n, input int base);
        for (int i = 0; i < n; i++) put(WIDTH'(base + i * 37));
    endtask

    task automatic drain();
        @(posedge rd_clk);
        #2 rd_en = 1'b1;
        wait (q.size() == 0);
        @(posedge rd_clk);
        #2 rd_en = 1'b0;
        settle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; ofs_load = 1'b0; ofs_ser_en = 1'b0;
        rtx_mark = 1'b0; rtx_go = 1'b0; rtx_clr = 1'b0;
        q.delete();
        repeat (3) @(posedge wr_clk);
        #2 rst_n = 1'b1;
        settle();
    endtask

    task automatic ser_load(input int af, input int ae);
        logic [2*OW-1:0] v;
        v = {OW'(af), OW'(ae)};
        for (int i = 2 * OW - 1; i >= 0; i--) begin
            @(posedge wr_clk);
            #2;
            ofs_ser_en  = 1'b1;
            ofs_ser_bit = v[i];
        end
        @(posedge wr_clk);
        #2 ofs_ser_en = 1'b0;
    endtask

    task automatic pulse_rd(input int which);
        @(posedge rd_clk);
        #2;
        if (which == 0) rtx_mark = 1'b1;
        else if (which == 1) rtx_go = 1'b1;
        else rtx_clr = 1'b1;
        @(posedge rd_clk);
        #2;
        rtx_mark = 1'b0; rtx_go = 1'b0; rtx_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        check("R1", WIDTH'(wr_ready),  1, "wr_ready after reset");
        check("R1", WIDTH'(wr_afull),  0, "wr_afull after reset");
        check("R1", WIDTH'(rd_valid),  0, "rd_valid after reset");
        check("R1", WIDTH'(rd_aempty), 1, "rd_aempty after reset");

        // R4: reading an empty queue does nothing
        req = "R4";
        @(posedge rd_clk);
        #2 rd_en = 1'b1;
        repeat (6) @(posedge rd_clk);
        #2 rd_en = 1'b0;
        settle();
        check("R4", WIDTH'(rd_valid), 0, "rd_valid after empty reads");
        fill(3, 'h40);
        settle();
        check("R4", WIDTH'(rd_valid), 1, "rd_valid after writes");
        drain();

        // R2: streaming with reads enabled throughout
        req = "R2";
        @(posedge rd_clk);
        #2 rd_en = 1'b1;
        fill(40, 'h100);
        drain();
        check("R2", WIDTH'(q.size()), 0, "scoreboard empty after stream");

        // R6 / R7 default almost-empty
        req = "R6";
        fill(8, 'h2000);
        settle();
        check("R7", WIDTH'(rd_aempty), 1, "aempty at 8 words, default offset");
        put(36'h2FFFF);
        settle();
        check("R6", WIDTH'(rd_aempty), 0, "aempty at 9 words");

        // R5 / R7 default almost-full
        fill(494, 'h3000);
        settle();
        check("R5", WIDTH'(wr_afull), 0, "afull at free 9");
        put(36'h3FFFF);
        settle();
        check("R7", WIDTH'(wr_afull), 1, "afull at free 8, default offset");
        fill(8, 'h5000);
        settle();
        check("R3", WIDTH'(wr_ready), 0, "wr_ready with DEPTH words");
        check("R5", WIDTH'(wr_afull), 1, "afull when full");

        // R3: writes while full are dropped
        req = "R3";
        @(posedge wr_clk);
        #2;
        wr_en   = 1'b1;
        wr_data = 36'hBAD;
        repeat (3) @(posedge wr_clk);
        #2 wr_en = 1'b0;
        settle();
        check("R3", WIDTH'(wr_ready), 0, "wr_ready after dropped writes");
        drain();
        check("R3", WIDTH'(rd_valid), 0, "no extra word after full drain");

        // R8 parallel load (AF=5, AE=3), then R10 ignored serial load
        req = "R8";
        @(posedge wr_clk);
        #2;
        wr_data = '0;
        wr_data[HALF +: OW] = OW'(5);
        wr_data[0 +: OW]    = OW'(3);
        ofs_load = 1'b1;
        wr_en    = 1'b1;
        @(posedge wr_clk);
        #2;
        ofs_load = 1'b0;
        wr_en    = 1'b0;
        ser_load(0, 0);
        fill(3, 'h6000);
        settle();
        check("R10", WIDTH'(rd_aempty), 1, "aempty at 3 words after ignored serial load");
        put(36'h6FFFF);
        settle();
        check("R8", WIDTH'(rd_aempty), 0, "aempty at 4 words, offset 3");
        fill(502, 'h7000);
        settle();
        check("R8", WIDTH'(wr_afull), 0, "afull at free 6, offset 5");
        put(36'h7FFFF);
        settle();
        check("R8", WIDTH'(wr_afull), 1, "afull at free 5, offset 5");
        drain();

        // R9 serial load (AF=20, AE=1)
        do_reset();
        req = "R9";
        ser_load(20, 1);
        put(36'h8000);
        settle();
        check("R9", WIDTH'(rd_aempty), 1, "aempty at 1 word, offset 1");
        put(36'h8001);
        settle();
        check("R9", WIDTH'(rd_aempty), 0, "aempty at 2 words");
        fill(489, 'h9000);
        settle();
        check("R9", WIDTH'(wr_afull), 0, "afull at free 21, offset 20");
        put(36'h9FFFF);
        settle();
        check("R9", WIDTH'(wr_afull), 1, "afull at free 20");
        drain();

        // R11 retransmit
        do_reset();
        req = "R11";
        fill(6, 'hA000);
        settle();
        @(posedge rd_clk);
        #2 rd_en = 1'b1;
        wait (q.size() == 4);
        @(posedge rd_clk);
        #2 rd_en = 1'b0;
        settle();
        check("R11", rd_data, WIDTH'('hA000 + 2 * 37), "word shown before mark");
        pulse_rd(0);
        @(posedge rd_clk);
        #2 rd_en = 1'b1;
        wait (q.size() == 1);
        @(posedge rd_clk);
        #2 rd_en = 1'b0;
        settle();
        pulse_rd(1);
        settle();
        check("R11", WIDTH'(rd_valid), 1, "word shown after rewind");
        check("R11", rd_data, WIDTH'('hA000 + 2 * 37), "marked word after rewind");
        q.push_front(WIDTH'('hA000 + 4 * 37));
        q.push_front(WIDTH'('hA000 + 3 * 37));
        q.push_front(WIDTH'('hA000 + 2 * 37));
        drain();

        // R12 protection while the mark is held (mark at word 2, 6 written)
        req = "R12";
        fill(508, 'hB000);
        settle();
        check("R12", WIDTH'(wr_ready), 0, "wr_ready with DEPTH words past mark");
        check("R12", WIDTH'(q.size()), 508, "words accepted while mark held");
        pulse_rd(2);
        settle();
        check("R12", WIDTH'(wr_ready), 1, "wr_ready after release");
        drain();

        report();
    end
endmodule